// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block takes one fetched 32-bit instruction word at a time and turns it into one or two issue strobes toward two execution slots, called left and right. The two top bits of the word choose the format. The format is either a single long instruction, or two short instructions that issue one after the other in a fixed order, or a parallel pair. In a parallel pair, a conditional-test instruction can gate its partner. Opcode decoding and the execution units sit outside the block. The environment reports back for each issued instruction whether it took a branch (with the target), whether it raised an exception, and the result flag of a conditional test. Each short instruction arrives with a bit that marks it as a conditional test.

When the word has finished, the block computes the next program counter. That value is either the branch target or the next word. A hardware repeat loop can also send the PC back to a start address. Eight saturating statistics counters record the accepted words by format, the outcomes of gated pairs and the issues skipped because of branches. A word is accepted through a valid/ready handshake. A small state machine then steps through idle, first issue, second issue and next-PC. A new word is accepted only after the next-PC step.

Top module: `dual_issue_seq`

## Requirements
- R1: Word bits 31:30 select the format. 11 gives one issue with slot code 3 and payload bits 29:0. 01 issues the left slot (code 1, bits 29:15) and then the right slot (code 2, bits 14:0). 10 issues right first and then left. Short payloads are zero-extended to 30 bits.
- R2: In a sequential pair (01 or 10), the second issue is dropped when the first issue reports a taken branch or an exception.
- R3: The branch-skip counter increases by one only when a sequential second issue is dropped because of a taken branch that came without an exception.
- R4: In a parallel pair (00), a left conditional test has priority. It issues first with role 1 (test), and the right slot issues next with role 2 (gated) only if the reported flag is 1. If only the right slot is a test, the right slot issues first and gates the left slot in the same way.
- R5: Each gated pair increments the condition-true counter or the condition-false counter, according to the flag returned by its test.
- R6: A parallel pair with no test issues left and then right, both with role 0 (plain). The right issue is dropped only when the left reports an exception. A taken branch does not drop it.
- R7: When a word completes, the next PC is the target of the last issue that reported a taken branch. If no issue reported one, the next PC is the old PC plus one. The PC changes at no other time.
- R8: While a repeat loop is armed and the post-execution PC equals the loop end, the remaining count is decremented. If the count reaches zero, the loop disarms and the R7 rule applies. Otherwise the PC is loaded with the loop start. Loading a count of zero disarms the loop.
- R9: The cycle counter increments once for each accepted word. The long, parallel, left-then-right and right-then-left counters each count the accepted words of their own format.
- R10: Every statistics counter stops at its all-ones value and never wraps or decreases.
- R11: Ready is high only in idle. The first issue comes in the cycle after acceptance, and a word holds the block for its issue cycles plus one next-PC cycle.
- R12: After synchronous reset the block is idle and ready, nothing is issued, the PC equals RESET_PC, the repeat loop is disarmed and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | A fetched word is offered |
| word_ready | output | 1 | Block is idle and takes the word |
| word_data | input | 32 | Fetched instruction word |
| left_is_test | input | 1 | Left short instruction is a conditional test |
| right_is_test | input | 1 | Right short instruction is a conditional test |
| res_taken | input | 1 | Current issue took a branch |
| res_target | input | PC_W | Branch target of the current issue |
| res_exc | input | 1 | Current issue raised an exception |
| res_flag | input | 1 | Condition result of the current test issue |
| rpt_load | input | 1 | Arm or disarm the repeat loop (honoured while idle) |
| rpt_start | input | PC_W | Loop start address |
| rpt_end | input | PC_W | Loop end address |
| rpt_count | input | RPT_W | Loop pass count; zero disarms |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_slot | output | 2 | 1 left, 2 right, 3 long |
| issue_role | output | 2 | 0 plain, 1 test, 2 gated |
| issue_insn | output | 30 | Issued instruction payload |
| pc | output | PC_W | Current program counter |
| rpt_busy | output | 1 | Repeat loop armed |
| cnt_cycles | output | CNT_W | Accepted words |
| cnt_long | output | CNT_W | Long words |
| cnt_par | output | CNT_W | Parallel words |
| cnt_lr | output | CNT_W | Left-then-right words |
| cnt_rl | output | CNT_W | Right-then-left words |
| cnt_true | output | CNT_W | Gated pairs with flag true |
| cnt_false | output | CNT_W | Gated pairs with flag false |
| cnt_bskip | output | CNT_W | Second issues skipped by a branch |

## Verification
A branch and the repeat loop can both act on the same word. In that case the loop-end compare must use the branch target, not the old PC. The bench arms a loop and then issues a long word whose branch target is exactly the loop end. It expects a decrement and a reload to the loop start. It also branches away from an armed loop end and expects the loop to stay armed. A second, narrow-counter instance runs the same stimulus, so that saturation and the per-format counts can be judged side by side.

// File: rtl/dis_pkg.sv
package dis_pkg;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_LEFT  = 2'd1,
    SLOT_RIGHT = 2'd2,
    SLOT_LONG  = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    ROLE_PLAIN = 2'd0,
    ROLE_TEST  = 2'd1,
    ROLE_GATED = 2'd2
  } role_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_NEXTPC = 2'd3
  } state_e;

  // rule that lets the second issue through
  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_SEQ  = 2'd1,
    GATE_FLAG = 2'd2,
    GATE_EXC  = 2'd3
  } gate_e;

  typedef struct packed {
    slot_e first;
    role_e first_role;
    slot_e second;
    role_e second_role;
    gate_e gate;
  } plan_t;

  localparam int NUM_STATS = 8;
  localparam int IX_CYCLE  = 0;
  localparam int IX_LONG   = 1;
  localparam int IX_PAR    = 2;
  localparam int IX_LR     = 3;
  localparam int IX_RL     = 4;
  localparam int IX_TRUE   = 5;
  localparam int IX_FALSE  = 6;
  localparam int IX_BSKIP  = 7;

  function automatic plan_t make_plan(logic [1:0] fmt_bits, logic lt, logic rt);
    plan_t p;
    p = '{SLOT_NONE, ROLE_PLAIN, SLOT_NONE, ROLE_PLAIN, GATE_NONE};
    case (fmt_e'(fmt_bits))
      FMT_LONG: p = '{SLOT_LONG, ROLE_PLAIN, SLOT_NONE, ROLE_PLAIN, GATE_NONE};
      FMT_LR:   p = '{SLOT_LEFT, ROLE_PLAIN, SLOT_RIGHT, ROLE_PLAIN, GATE_SEQ};
      FMT_RL:   p = '{SLOT_RIGHT, ROLE_PLAIN, SLOT_LEFT, ROLE_PLAIN, GATE_SEQ};
      default: begin
        if (lt)      p = '{SLOT_LEFT, ROLE_TEST, SLOT_RIGHT, ROLE_GATED, GATE_FLAG};
        else if (rt) p = '{SLOT_RIGHT, ROLE_TEST, SLOT_LEFT, ROLE_GATED, GATE_FLAG};
        else         p = '{SLOT_LEFT, ROLE_PLAIN, SLOT_RIGHT, ROLE_PLAIN, GATE_EXC};
      end
    endcase
    return p;
  endfunction

  function automatic logic [29:0] pick_slot(logic [29:0] body, slot_e s);
    case (s)
      SLOT_LONG:  return body;
      SLOT_LEFT:  return {15'd0, body[29:15]};
      SLOT_RIGHT: return {15'd0, body[14:0]};
      default:    return '0;
    endcase
  endfunction

  function automatic logic second_allowed(gate_e g, logic taken, logic exc, logic flag);
    case (g)
      GATE_SEQ:  return !taken && !exc;
      GATE_FLAG: return flag;
      GATE_EXC:  return !exc;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dis_sat_counter.sv
module dis_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] sat_next(logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (bump) value <= sat_next(value);
  end
endmodule

// File: rtl/dis_stat_bank.sv
module dis_stat_bank #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        bump,
  output logic [N-1:0][W-1:0] values
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    dis_sat_counter #(.W(W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .bump  (bump[g]),
      .value (values[g])
    );
  end
endmodule

// File: rtl/dis_pc_unit.sv
module dis_pc_unit #(
  parameter int          PC_W     = 16,
  parameter int          RPT_W    = 16,
  parameter int unsigned RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             chg,
  input  logic [PC_W-1:0]  tgt,
  input  logic             load,
  input  logic [PC_W-1:0]  ld_start,
  input  logic [PC_W-1:0]  ld_end,
  input  logic [RPT_W-1:0] ld_count,
  output logic [PC_W-1:0]  pc,
  output logic             busy,
  output logic             loop_hit,
  output logic             loop_end
);
  logic [PC_W-1:0]  pc_q, start_q, end_q;
  logic [RPT_W-1:0] left_q;
  logic             busy_q;
  logic [PC_W-1:0]  after_exec;

  function automatic logic [PC_W-1:0] plain_next(logic c, logic [PC_W-1:0] t,
                                                 logic [PC_W-1:0] p);
    return c ? t : p + 1'b1;
  endfunction

  assign after_exec = chg ? tgt : pc_q;
  assign loop_hit   = step && busy_q && (after_exec == end_q);
  assign loop_end   = loop_hit && (left_q == RPT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= PC_W'(RESET_PC);
      start_q <= '0;
      end_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (loop_hit) begin
      left_q <= left_q - 1'b1;
      if (loop_end) begin
        busy_q <= 1'b0;
        pc_q   <= plain_next(chg, tgt, pc_q);
      end else begin
        pc_q <= start_q;
      end
    end else if (step) begin
      pc_q <= plain_next(chg, tgt, pc_q);
    end else if (load) begin
      start_q <= ld_start;
      end_q   <= ld_end;
      left_q  <= ld_count;
      busy_q  <= (ld_count != '0);
    end
  end

  assign pc   = pc_q;
  assign busy = busy_q;
endmodule

// File: rtl/dual_issue_seq.sv
module dual_issue_seq
  import dis_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          RPT_W    = 16,
  parameter int          CNT_W    = 32,
  parameter int unsigned RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  output logic             word_ready,
  input  logic [31:0]      word_data,
  input  logic             left_is_test,
  input  logic             right_is_test,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  input  logic             res_exc,
  input  logic             res_flag,
  input  logic             rpt_load,
  input  logic [PC_W-1:0]  rpt_start,
  input  logic [PC_W-1:0]  rpt_end,
  input  logic [RPT_W-1:0] rpt_count,
  output logic             issue_valid,
  output logic [1:0]       issue_slot,
  output logic [1:0]       issue_role,
  output logic [29:0]      issue_insn,
  output logic [PC_W-1:0]  pc,
  output logic             rpt_busy,
  output logic [CNT_W-1:0] cnt_cycles,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_par,
  output logic [CNT_W-1:0] cnt_lr,
  output logic [CNT_W-1:0] cnt_rl,
  output logic [CNT_W-1:0] cnt_true,
  output logic [CNT_W-1:0] cnt_false,
  output logic [CNT_W-1:0] cnt_bskip
);
  state_e          st_q, st_d;
  logic [29:0]     body_q;
  plan_t           plan_q, plan_in;
  logic            chg_q;
  logic [PC_W-1:0] tgt_q;
  fmt_e            fmt_in;
  slot_e           cur_slot;
  role_e           cur_role;

  // named internal events
  logic accept, in_first, in_second, go_second;
  logic ev_branch_skip, ev_cond_true, ev_cond_false, ev_pc_step;
  logic ev_loop_hit, ev_loop_end;
  logic [NUM_STATS-1:0]            bump;
  logic [NUM_STATS-1:0][CNT_W-1:0] stat_vals;

  assign word_ready = (st_q == ST_IDLE);
  assign accept     = word_ready && word_valid;
  assign fmt_in     = fmt_e'(word_data[31:30]);
  assign plan_in    = make_plan(word_data[31:30], left_is_test, right_is_test);
  assign in_first   = (st_q == ST_FIRST);
  assign in_second  = (st_q == ST_SECOND);
  assign ev_pc_step = (st_q == ST_NEXTPC);
  assign go_second  = in_first && second_allowed(plan_q.gate, res_taken, res_exc, res_flag);

  assign ev_branch_skip = in_first && (plan_q.gate == GATE_SEQ) && res_taken && !res_exc;
  assign ev_cond_true   = in_first && (plan_q.gate == GATE_FLAG) && res_flag;
  assign ev_cond_false  = in_first && (plan_q.gate == GATE_FLAG) && !res_flag;

  always_comb begin
    cur_slot = SLOT_NONE;
    cur_role = ROLE_PLAIN;
    if (in_first) begin
      cur_slot = plan_q.first;
      cur_role = plan_q.first_role;
    end else if (in_second) begin
      cur_slot = plan_q.second;
      cur_role = plan_q.second_role;
    end
  end

  assign issue_valid = in_first || in_second;
  assign issue_slot  = cur_slot;
  assign issue_role  = cur_role;
  assign issue_insn  = pick_slot(body_q, cur_slot);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (accept) st_d = ST_FIRST;
      ST_FIRST:  st_d = go_second ? ST_SECOND : ST_NEXTPC;
      ST_SECOND: st_d = ST_NEXTPC;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      body_q <= '0;
      plan_q <= '{SLOT_NONE, ROLE_PLAIN, SLOT_NONE, ROLE_PLAIN, GATE_NONE};
      chg_q  <= 1'b0;
      tgt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        body_q <= word_data[29:0];
        plan_q <= plan_in;
        chg_q  <= 1'b0;
      end else if (issue_valid && res_taken) begin
        chg_q <= 1'b1;
        tgt_q <= res_target;
      end
    end
  end

  dis_pc_unit #(
    .PC_W     (PC_W),
    .RPT_W    (RPT_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .step     (ev_pc_step),
    .chg      (chg_q),
    .tgt      (tgt_q),
    .load     (rpt_load && word_ready),
    .ld_start (rpt_start),
    .ld_end   (rpt_end),
    .ld_count (rpt_count),
    .pc       (pc),
    .busy     (rpt_busy),
    .loop_hit (ev_loop_hit),
    .loop_end (ev_loop_end)
  );

  always_comb begin
    bump           = '0;
    bump[IX_CYCLE] = accept;
    bump[IX_LONG]  = accept && (fmt_in == FMT_LONG);
    bump[IX_PAR]   = accept && (fmt_in == FMT_PAR);
    bump[IX_LR]    = accept && (fmt_in == FMT_LR);
    bump[IX_RL]    = accept && (fmt_in == FMT_RL);
    bump[IX_TRUE]  = ev_cond_true;
    bump[IX_FALSE] = ev_cond_false;
    bump[IX_BSKIP] = ev_branch_skip;
  end

  dis_stat_bank #(.N(NUM_STATS), .W(CNT_W)) u_stats (
    .clk    (clk),
    .rst    (rst),
    .bump   (bump),
    .values (stat_vals)
  );

  assign cnt_cycles = stat_vals[IX_CYCLE];
  assign cnt_long   = stat_vals[IX_LONG];
  assign cnt_par    = stat_vals[IX_PAR];
  assign cnt_lr     = stat_vals[IX_LR];
  assign cnt_rl     = stat_vals[IX_RL];
  assign cnt_true   = stat_vals[IX_TRUE];
  assign cnt_false  = stat_vals[IX_FALSE];
  assign cnt_bskip  = stat_vals[IX_BSKIP];
endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid,
  input logic             word_ready,
  input logic             issue_valid,
  input logic [1:0]       issue_slot,
  input logic [1:0]       issue_role,
  input logic             res_flag,
  input logic [PC_W-1:0]  pc,
  input logic             rpt_busy,
  input logic [CNT_W-1:0] cnt_cycles,
  input logic [CNT_W-1:0] cnt_bskip,
  input logic             ev_branch_skip,
  input logic             ev_loop_end,
  input logic             ev_pc_step
);
  AST_NO_READY_WHILE_ISSUING: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !word_ready); // R11

  AST_ACCEPT_THEN_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> issue_valid); // R11

  AST_LONG_ISSUES_ALONE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_slot == 2'd3) |=> !issue_valid); // R1

  AST_GATED_AFTER_TRUE_TEST: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_role == 2'd2) |->
      ($past(issue_valid) && $past(issue_role) == 2'd1 && $past(res_flag))); // R4

  AST_PC_MOVES_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> $past(ev_pc_step)); // R7

  AST_LOOP_END_DISARMS: assert property (@(posedge clk) disable iff (rst)
    ev_loop_end |=> !rpt_busy); // R8

  AST_BSKIP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    ev_branch_skip |=> ((cnt_bskip == $past(cnt_bskip) + 1'b1) || (&$past(cnt_bskip)))); // R3

  AST_CYCLES_NEVER_DROP: assert property (@(posedge clk) disable iff (rst)
    cnt_cycles >= $past(cnt_cycles)); // R10
endmodule

bind dual_issue_seq dis_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .word_valid     (word_valid),
  .word_ready     (word_ready),
  .issue_valid    (issue_valid),
  .issue_slot     (issue_slot),
  .issue_role     (issue_role),
  .res_flag       (res_flag),
  .pc             (pc),
  .rpt_busy       (rpt_busy),
  .cnt_cycles     (cnt_cycles),
  .cnt_bskip      (cnt_bskip),
  .ev_branch_skip (ev_branch_skip),
  .ev_loop_end    (ev_loop_end),
  .ev_pc_step     (ev_pc_step)
);

// File: tb/test_dual_issue_seq.sv
`timescale 1ns/1ps
module test_dual_issue_seq;
  localparam int PC_W = 16;
  localparam int RPT_W = 16;
  localparam int CNT_W = 32;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic left_is_test = 1'b0, right_is_test = 1'b0;
  logic res_taken = 1'b0, res_exc = 1'b0, res_flag = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic rpt_load = 1'b0;
  logic [PC_W-1:0] rpt_start = '0, rpt_end = '0;
  logic [RPT_W-1:0] rpt_count = '0;

  logic word_ready, issue_valid, rpt_busy;
  logic [1:0] issue_slot, issue_role;
  logic [29:0] issue_insn;
  logic [PC_W-1:0] pc;
  logic [CNT_W-1:0] c_cyc, c_long, c_par, c_lr, c_rl, c_true, c_false, c_bskip;

  logic n_ready, n_valid, n_busy;
  logic [1:0] n_slot, n_role;
  logic [29:0] n_insn;
  logic [PC_W-1:0] n_pc;
  logic [NW-1:0] n_cyc, n_long, n_par, n_lr, n_rl, n_true, n_false, n_bskip;

  always #2.5 clk = ~clk;

  dual_issue_seq #(.PC_W(PC_W), .RPT_W(RPT_W), .CNT_W(CNT_W)) i_dual_issue_seq (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .left_is_test(left_is_test), .right_is_test(right_is_test),
    .res_taken(res_taken), .res_target(res_target), .res_exc(res_exc), .res_flag(res_flag),
    .rpt_load(rpt_load), .rpt_start(rpt_start), .rpt_end(rpt_end), .rpt_count(rpt_count),
    .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_role(issue_role),
    .issue_insn(issue_insn), .pc(pc), .rpt_busy(rpt_busy),
    .cnt_cycles(c_cyc), .cnt_long(c_long), .cnt_par(c_par), .cnt_lr(c_lr), .cnt_rl(c_rl),
    .cnt_true(c_true), .cnt_false(c_false), .cnt_bskip(c_bskip));

  dual_issue_seq #(.PC_W(PC_W), .RPT_W(RPT_W), .CNT_W(NW)) i_dual_issue_seq_narrow (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(n_ready),
    .word_data(word_data), .left_is_test(left_is_test), .right_is_test(right_is_test),
    .res_taken(res_taken), .res_target(res_target), .res_exc(res_exc), .res_flag(res_flag),
    .rpt_load(rpt_load), .rpt_start(rpt_start), .rpt_end(rpt_end), .rpt_count(rpt_count),
    .issue_valid(n_valid), .issue_slot(n_slot), .issue_role(n_role),
    .issue_insn(n_insn), .pc(n_pc), .rpt_busy(n_busy),
    .cnt_cycles(n_cyc), .cnt_long(n_long), .cnt_par(n_par), .cnt_lr(n_lr), .cnt_rl(n_rl),
    .cnt_true(n_true), .cnt_false(n_false), .cnt_bskip(n_bskip));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // result bits: [2] taken, [1] exception, [0] flag
  typedef struct packed {
    logic [31:0] w;
    logic lt; logic rt;
    logic [2:0] r1; logic [2:0] r2;
    logic [15:0] tgt;
    logic [1:0] n;
    logic [1:0] s1; logic [1:0] o1;
    logic [1:0] s2; logic [1:0] o2;
    logic [15:0] pc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'hC012_3456, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 16'h0001},
    '{32'h4000_8001, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 2'd2, 2'd1, 2'd0, 2'd2, 2'd0, 16'h0002},
    '{32'h8123_4567, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 2'd2, 2'd2, 2'd0, 2'd1, 2'd0, 16'h0003},
    '{32'h4765_4321, 1'b0, 1'b0, 3'd4, 3'd0, 16'h0040, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 16'h0040},
    '{32'h8000_7FFF, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0000, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 16'h0041},
    '{32'h0ABC_DEF0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000, 2'd2, 2'd1, 2'd0, 2'd2, 2'd0, 16'h0042},
    '{32'h1111_2222, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0000, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 16'h0043},
    '{32'h2222_3333, 1'b1, 1'b0, 3'd1, 3'd0, 16'h0000, 2'd2, 2'd1, 2'd1, 2'd2, 2'd2, 16'h0044},
    '{32'h3333_4444, 1'b1, 1'b0, 3'd0, 3'd0, 16'h0000, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 16'h0045},
    '{32'h0000_5555, 1'b0, 1'b1, 3'd1, 3'd0, 16'h0000, 2'd2, 2'd2, 2'd1, 2'd1, 2'd2, 16'h0046},
    '{32'h1234_0000, 1'b1, 1'b1, 3'd0, 3'd0, 16'h0000, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 16'h0047},
    '{32'h7FFF_FFFF, 1'b0, 1'b0, 3'd0, 3'd4, 16'h0010, 2'd2, 2'd1, 2'd0, 2'd2, 2'd0, 16'h0010},
    '{32'h2468_ACE0, 1'b0, 1'b0, 3'd4, 3'd0, 16'h0020, 2'd2, 2'd1, 2'd0, 2'd2, 2'd0, 16'h0020},
    '{32'h5555_AAAA, 1'b0, 1'b0, 3'd6, 3'd0, 16'h0030, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 16'h0030}
  };

  logic [1:0] got_slot [2];
  logic [1:0] got_role [2];
  logic [29:0] got_insn [2];
  int got_n;
  int busy_cycles;

  function automatic logic [29:0] exp_insn(logic [31:0] w, logic [1:0] s);
    case (s)
      2'd3: return w[29:0];
      2'd1: return {15'd0, w[29:15]};
      2'd2: return {15'd0, w[14:0]};
      default: return '0;
    endcase
  endfunction

  function automatic string row_tag(vec_t v);
    if (v.w[31:30] == 2'b11) return "R1";
    if (v.w[31:30] == 2'b00) return (v.lt || v.rt) ? "R4" : "R6";
    return (v.n == 2'd1) ? "R2" : "R1";
  endfunction

  task automatic run_word(input logic [31:0] w, input logic lt, input logic rt,
                          input logic [2:0] r1, input logic [2:0] r2, input logic [15:0] tgt);
    @(negedge clk);
    word_valid = 1'b1; word_data = w; left_is_test = lt; right_is_test = rt;
    @(negedge clk);
    word_valid = 1'b0;
    got_n = 0;
    busy_cycles = 0;
    for (int k = 0; k < 6; k++) begin
      if (word_ready) break;
      busy_cycles++;
      if (issue_valid) begin
        if (got_n < 2) begin
          got_slot[got_n] = issue_slot;
          got_role[got_n] = issue_role;
          got_insn[got_n] = issue_insn;
        end
        {res_taken, res_exc, res_flag} = (got_n == 0) ? r1 : r2;
        res_target = tgt;
        got_n++;
      end else begin
        {res_taken, res_exc, res_flag} = 3'b000;
      end
      @(negedge clk);
    end
    {res_taken, res_exc, res_flag} = 3'b000;
  endtask

  task automatic load_rpt(input logic [15:0] s, input logic [15:0] e, input logic [15:0] c);
    @(negedge clk);
    rpt_load = 1'b1; rpt_start = s; rpt_end = e; rpt_count = c;
    @(negedge clk);
    rpt_load = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 ready", word_ready, 1);
    chk("R12 issue", issue_valid, 0);
    chk("R12 pc", pc, 0);
    chk("R12 busy", rpt_busy, 0);
    chk("R12 cycles", c_cyc, 0);
    chk("R12 bskip", c_bskip, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      run_word(v.w, v.lt, v.rt, v.r1, v.r2, v.tgt);
      chk($sformatf("%s row%0d count", row_tag(v), i), got_n, v.n);
      chk($sformatf("%s row%0d slot1", row_tag(v), i), got_slot[0], v.s1);
      chk($sformatf("%s row%0d role1", row_tag(v), i), got_role[0], v.o1);
      chk($sformatf("R1 row%0d insn1", i), got_insn[0], exp_insn(v.w, v.s1));
      if (v.n == 2'd2) begin
        chk($sformatf("%s row%0d slot2", row_tag(v), i), got_slot[1], v.s2);
        chk($sformatf("%s row%0d role2", row_tag(v), i), got_role[1], v.o2);
        chk($sformatf("R1 row%0d insn2", i), got_insn[1], exp_insn(v.w, v.s2));
      end
      chk($sformatf("R11 row%0d busy cycles", i), busy_cycles, got_n + 1);
      chk($sformatf("R7 row%0d pc", i), pc, v.pc);
    end

    chk("R9 cycles", c_cyc, 14);
    chk("R9 long", c_long, 1);
    chk("R9 parallel", c_par, 7);
    chk("R9 left-right", c_lr, 4);
    chk("R9 right-left", c_rl, 2);
    chk("R5 true", c_true, 2);
    chk("R5 false", c_false, 2);
    chk("R3 branch skip", c_bskip, 1);

    // R8 repeat loop over 0x100..0x101, three passes
    load_rpt(16'h0100, 16'h0101, 16'd3);
    chk("R8 armed", rpt_busy, 1);
    run_word(32'hC000_0000, 1'b0, 1'b0, 3'd4, 3'd0, 16'h0100);
    chk("R7 jump into loop", pc, 16'h0100);
    run_word(32'hC000_0001, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 pass1 body", pc, 16'h0101);
    run_word(32'hC000_0002, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 pass1 reload", pc, 16'h0100);
    run_word(32'hC000_0001, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 pass2 body", pc, 16'h0101);
    run_word(32'hC000_0002, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 pass2 reload", pc, 16'h0100);
    chk("R8 still armed", rpt_busy, 1);
    run_word(32'hC000_0001, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    run_word(32'hC000_0002, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 exit falls through", pc, 16'h0102);
    chk("R8 disarmed", rpt_busy, 0);
    run_word(32'hC000_0003, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 no loop after exit", pc, 16'h0103);

    // R8 branch landing on the loop end in the same word
    load_rpt(16'h0200, 16'h0201, 16'd2);
    run_word(32'hC000_0004, 1'b0, 1'b0, 3'd4, 3'd0, 16'h0201);
    chk("R8 branch onto end reloads", pc, 16'h0200);
    run_word(32'hC000_0005, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 body after collision", pc, 16'h0201);
    run_word(32'hC000_0006, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000);
    chk("R8 last pass exit", pc, 16'h0202);
    chk("R8 collision disarm", rpt_busy, 0);

    // R8 branch away from an armed end keeps the loop, zero count disarms
    load_rpt(16'h0300, 16'h0202, 16'd5);
    run_word(32'hC000_0007, 1'b0, 1'b0, 3'd4, 3'd0, 16'h0400);
    chk("R8 branch away", pc, 16'h0400);
    chk("R8 armed after branch away", rpt_busy, 1);
    load_rpt(16'h0000, 16'h0000, 16'd0);
    chk("R8 zero count disarms", rpt_busy, 0);
    chk("R8 disarm keeps pc", pc, 16'h0400);

    // R9 / R10 totals on both widths
    chk("R9 total cycles", c_cyc, 26);
    chk("R9 total long", c_long, 13);
    chk("R10 narrow cycles saturate", n_cyc, 7);
    chk("R10 narrow long saturate", n_long, 7);
    chk("R10 narrow parallel at top", n_par, 7);
    chk("R10 narrow lr below top", n_lr, 4);
    chk("R10 narrow rl below top", n_rl, 2);
    chk("R10 narrow pc unaffected", n_pc, pc);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule